// File: doc/BRIEF.md
# Fixed-Point 8x8 Forward DCT Coprocessor

This block is a host-attached coprocessor that performs a two-dimensional forward discrete cosine transform on one 8x8 block of signed 8-bit pixels, using integer arithmetic with 6 fractional bits. The host reaches it through four byte-wide registers on a small bus. It streams 64 pixels into the data-in register, writes 1 to the command register and polls the status register until the busy bit clears. It then pulls 64 signed 16-bit coefficients out of the data-out register, two byte reads per coefficient.

Internally there is a 64-entry input buffer, a 64-entry output buffer, a cosine constant table and one shared multiplier. The multiplier serves both summation passes and the final scaling step. Every product is truncated by an arithmetic right shift before it is accumulated. A fixed normalisation weight and a final 12-bit shift are then applied. The results follow that exact integer sequence and are not a mathematically exact DCT.

Top module: `dct_coproc`

## Requirements
- R1: Register map on `addr_i`: 0 = pixel write, 1 = coefficient read, 2 = command write, 3 = status read. Status returns the busy flag in bit 0 with bits 7:1 zero. Reads of addresses 0 and 2 return 0.
- R2: Each pixel write stores the signed byte multiplied by 64 at a write index that runs 0..63 in row-major order, where row = index/8 and column = index%8. After index 63 the write index wraps to 0, so a 65th write overwrites entry 0.
- R3: Writing exactly 8'h01 to the command register while idle starts a transform. Any other command value leaves the block idle.
- R4: After an accepted start, the status reads 1 for exactly 4672 clock cycles, which is 64 coefficients at 73 cycles each, and then reads 0.
- R5: A command write made while busy is ignored. The busy time and the results are the same as for an uninterrupted transform.
- R6: With cosine constant K[a][b] = trunc(64·cos((2a+1)·b·π/16)), the block computes s[x] = Σj (P[x][j]·K[j][v]) >>> 6 and r = Σx (s[x]·K[x][u]) >>> 6 for coefficient (u,v). P is the stored, scaled pixel.
- R7: The coefficient is (r·w) >>> 12, truncated to 16 bits. The weight w = ((((16·c(u))>>6)·c(v))>>6) with c(0)=5 and c(k≠0)=64. This gives w = 0 for (0,0), 1 when exactly one of u and v is 0, and 16 otherwise.
- R8: Coefficients are read in order of increasing u and then v, with index = u·8+v. Each coefficient is returned as its high byte and then its low byte on consecutive data-out reads.
- R9: The read index returns to coefficient 0, high byte, when a transform is accepted. It advances after every second data-out read and wraps from 63 to 0.
- R10: After reset the status reads 0, the write and read indices are 0, and every stored coefficient reads as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 2 | Register select |
| wr_i | input | 1 | Write strobe, one cycle per access |
| rd_i | input | 1 | Read strobe, one cycle per access; advances the data-out byte pointer |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from `addr_i` |

## Verification
The transform is driven with an all-zero block, a flat block and a single impulse. The flat block produces nothing in the zero-weighted DC term and exposes any error in the weight table. The impulse singles out one row and one column of the cosine table. A signed ramp, a full-scale alternating block and a pseudo-random block exercise the negative products and the truncation of every shifted product, which a rounding or logical-shift datapath would get wrong. Command writes with other values and during busy, an overfilled pixel stream, and reads across the end of the output buffer and across a restart separate the index and handshake rules from the arithmetic.

// File: rtl/dct_pkg.sv
package dct_pkg;

  localparam int unsigned BLK_N  = 8;   // block side; cosine table below is for 8
  localparam int unsigned PIX_W  = 8;
  localparam int unsigned FRAC_W = 6;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned ACC_W  = 32;
  localparam int unsigned COS_W  = 8;
  localparam int unsigned DC_C   = 5;
  localparam int unsigned AC_C   = 64;

  typedef enum logic [1:0] {
    REG_PIX_IN  = 2'd0,
    REG_COEF_OUT = 2'd1,
    REG_CMD     = 2'd2,
    REG_STAT    = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACC,
    ST_ROW,
    ST_SCALE
  } eng_state_e;

  // trunc(64*cos((2a+1)*b*pi/16)) built from folded octant magnitudes
  function automatic int cos_coef(int a, int b);
    int m;
    int mag;
    bit neg;
    m   = ((2 * a + 1) * b) % 32;
    neg = 1'b0;
    if (m > 16) m = 32 - m;
    if (m > 8) begin
      m   = 16 - m;
      neg = 1'b1;
    end
    case (m)
      0:       mag = 64;
      1:       mag = 62;
      2:       mag = 59;
      3:       mag = 53;
      4:       mag = 45;
      5:       mag = 35;
      6:       mag = 24;
      7:       mag = 12;
      default: mag = 0;
    endcase
    return neg ? -mag : mag;
  endfunction

  function automatic int norm_weight(bit u_nz, bit v_nz);
    int cu;
    int cv;
    cu = u_nz ? AC_C : DC_C;
    cv = v_nz ? AC_C : DC_C;
    return ((((16 * cu) >> FRAC_W) * cv) >> FRAC_W);
  endfunction

endpackage

// File: rtl/dct_cos_rom.sv
module dct_cos_rom
  import dct_pkg::*;
#(
  parameter int unsigned N     = BLK_N,
  parameter int unsigned CW    = COS_W,
  localparam int unsigned IW   = $clog2(N)
) (
  input  logic [IW-1:0]        row_i,
  input  logic [IW-1:0]        col_i,
  output logic signed [CW-1:0] coef_o
);

  logic signed [CW-1:0] tbl [N*N];

  for (genvar r = 0; r < N; r++) begin : g_row
    for (genvar c = 0; c < N; c++) begin : g_col
      assign tbl[r*N+c] = CW'(cos_coef(r, c));
    end
  end

  assign coef_o = tbl[{row_i, col_i}];

endmodule

// File: rtl/dct_host_if.sv
module dct_host_if
  import dct_pkg::*;
#(
  parameter int unsigned N    = BLK_N,
  parameter int unsigned PW   = PIX_W,
  parameter int unsigned FW   = FRAC_W,
  parameter int unsigned DW   = DATA_W,
  localparam int unsigned AW  = 2 * $clog2(N)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [1:0]           addr_i,
  input  logic                 wr_i,
  input  logic                 rd_i,
  input  logic [PW-1:0]        wdata_i,
  output logic [PW-1:0]        rdata_o,
  input  logic                 busy_i,
  output logic                 start_o,
  output logic                 in_we_o,
  output logic [AW-1:0]        in_waddr_o,
  output logic signed [DW-1:0] in_wdata_o,
  output logic [AW-1:0]        out_raddr_o,
  input  logic signed [DW-1:0] out_rdata_i
);

  localparam int unsigned EXT_W = DW - PW - FW;

  logic [AW-1:0] wr_idx;
  logic [AW-1:0] rd_idx;
  logic          rd_lo;
  logic          rd_coef;

  assign start_o    = wr_i && (addr_i == REG_CMD) && (wdata_i == PW'(1)) && !busy_i;
  assign in_we_o    = wr_i && (addr_i == REG_PIX_IN);
  assign in_waddr_o = wr_idx;
  assign in_wdata_o = {{EXT_W{wdata_i[PW-1]}}, wdata_i, {FW{1'b0}}};
  assign out_raddr_o = rd_idx;
  assign rd_coef    = rd_i && (addr_i == REG_COEF_OUT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_idx <= '0;
    end else if (in_we_o) begin
      wr_idx <= wr_idx + 1'b1;  // wraps after N*N-1
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_idx <= '0;
      rd_lo  <= 1'b0;
    end else if (start_o) begin
      rd_idx <= '0;
      rd_lo  <= 1'b0;
    end else if (rd_coef) begin
      rd_lo <= ~rd_lo;
      if (rd_lo) rd_idx <= rd_idx + 1'b1;
    end
  end

  always_comb begin
    case (addr_i)
      REG_COEF_OUT: rdata_o = rd_lo ? out_rdata_i[PW-1:0] : out_rdata_i[DW-1:DW-PW];
      REG_STAT:     rdata_o = {{(PW-1){1'b0}}, busy_i};
      default:      rdata_o = '0;
    endcase
  end

endmodule

// File: rtl/dct_mac_engine.sv
module dct_mac_engine
  import dct_pkg::*;
#(
  parameter int unsigned N    = BLK_N,
  parameter int unsigned FW   = FRAC_W,
  parameter int unsigned DW   = DATA_W,
  parameter int unsigned AccW = ACC_W,
  parameter int unsigned CW   = COS_W,
  localparam int unsigned IW  = $clog2(N),
  localparam int unsigned AW  = 2 * IW,
  localparam int unsigned PRW = AccW + CW
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  output logic                 busy_o,
  output logic [AW-1:0]        in_raddr_o,
  input  logic signed [DW-1:0] in_rdata_i,
  output logic                 out_we_o,
  output logic [AW-1:0]        out_waddr_o,
  output logic signed [DW-1:0] out_wdata_o
);

  localparam logic [IW-1:0] LAST = IW'(N - 1);

  eng_state_e state;
  logic [IW-1:0] x_q, j_q, u_q, v_q;
  logic signed [AccW-1:0] s_acc, r_acc;

  logic [IW-1:0]           rom_row, rom_col;
  logic signed [CW-1:0]    cos_val;
  logic signed [CW-1:0]    weight;
  logic signed [AccW-1:0]  mul_a;
  logic signed [CW-1:0]    mul_b;
  logic signed [PRW-1:0]   prod;

  dct_cos_rom #(.N(N), .CW(CW)) u_rom (
    .row_i  (rom_row),
    .col_i  (rom_col),
    .coef_o (cos_val)
  );

  // second pass indexes the table by (x,u), first pass by (j,v)
  assign rom_row = (state == ST_ROW) ? x_q : j_q;
  assign rom_col = (state == ST_ROW) ? u_q : v_q;
  assign weight  = CW'(norm_weight(u_q != '0, v_q != '0));

  always_comb begin
    case (state)
      ST_ROW: begin
        mul_a = s_acc;
        mul_b = cos_val;
      end
      ST_SCALE: begin
        mul_a = r_acc;
        mul_b = weight;
      end
      default: begin
        mul_a = AccW'(in_rdata_i);
        mul_b = cos_val;
      end
    endcase
  end

  assign prod = PRW'(mul_a) * PRW'(mul_b);

  assign busy_o      = (state != ST_IDLE);
  assign in_raddr_o  = {x_q, j_q};
  assign out_we_o    = (state == ST_SCALE);
  assign out_waddr_o = {u_q, v_q};
  assign out_wdata_o = DW'(prod >>> (2 * FW));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state <= ST_IDLE;
      x_q   <= '0;
      j_q   <= '0;
      u_q   <= '0;
      v_q   <= '0;
      s_acc <= '0;
      r_acc <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start_i) begin
            state <= ST_ACC;
            x_q   <= '0;
            j_q   <= '0;
            u_q   <= '0;
            v_q   <= '0;
            s_acc <= '0;
            r_acc <= '0;
          end
        end
        ST_ACC: begin
          s_acc <= s_acc + AccW'(prod >>> FW);
          j_q   <= j_q + 1'b1;
          if (j_q == LAST) state <= ST_ROW;
        end
        ST_ROW: begin
          r_acc <= r_acc + AccW'(prod >>> FW);
          s_acc <= '0;
          x_q   <= x_q + 1'b1;
          state <= (x_q == LAST) ? ST_SCALE : ST_ACC;
        end
        ST_SCALE: begin
          r_acc <= '0;
          v_q   <= v_q + 1'b1;
          if (v_q == LAST) u_q <= u_q + 1'b1;
          state <= (u_q == LAST && v_q == LAST) ? ST_IDLE : ST_ACC;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dct_coproc.sv
module dct_coproc
  import dct_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] addr_i,
  input  logic       wr_i,
  input  logic       rd_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o
);

  localparam int unsigned N  = BLK_N;
  localparam int unsigned AW = 2 * $clog2(N);
  localparam int unsigned NE = N * N;

  logic                     start, busy;
  logic                     in_we, out_we;
  logic [AW-1:0]            in_waddr, in_raddr, out_waddr, out_raddr;
  logic signed [DATA_W-1:0] in_wdata, in_rdata, out_wdata, out_rdata;

  logic signed [DATA_W-1:0] in_buf  [NE];
  logic signed [DATA_W-1:0] out_buf [NE];

  dct_host_if #(.N(N), .PW(PIX_W), .FW(FRAC_W), .DW(DATA_W)) u_host (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .addr_i      (addr_i),
    .wr_i        (wr_i),
    .rd_i        (rd_i),
    .wdata_i     (wdata_i),
    .rdata_o     (rdata_o),
    .busy_i      (busy),
    .start_o     (start),
    .in_we_o     (in_we),
    .in_waddr_o  (in_waddr),
    .in_wdata_o  (in_wdata),
    .out_raddr_o (out_raddr),
    .out_rdata_i (out_rdata)
  );

  dct_mac_engine #(.N(N), .FW(FRAC_W), .DW(DATA_W), .AccW(ACC_W), .CW(COS_W)) u_eng (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .busy_o      (busy),
    .in_raddr_o  (in_raddr),
    .in_rdata_i  (in_rdata),
    .out_we_o    (out_we),
    .out_waddr_o (out_waddr),
    .out_wdata_o (out_wdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NE; i++) in_buf[i] <= '0;
    end else if (in_we) begin
      in_buf[in_waddr] <= in_wdata;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NE; i++) out_buf[i] <= '0;
    end else if (out_we) begin
      out_buf[out_waddr] <= out_wdata;
    end
  end

  assign in_rdata  = in_buf[in_raddr];
  assign out_rdata = out_buf[out_raddr];

endmodule

// File: rtl/dct_coproc_chk.sv
module dct_coproc_chk
  import dct_pkg::*;
#(
  parameter int unsigned N   = BLK_N,
  localparam int unsigned AW = 2 * $clog2(N),
  localparam int unsigned BUSY_CYC = N * N * (N * (N + 1) + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          busy_i,
  input logic          out_we_i,
  input logic [AW-1:0] out_waddr_i,
  input logic [AW-1:0] out_raddr_i,
  input logic [1:0]    addr_i,
  input logic [7:0]    rdata_i
);

  logic [31:0]   busy_cnt;
  logic [AW-1:0] exp_waddr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_cnt  <= '0;
      exp_waddr <= '0;
    end else begin
      if (start_i)     busy_cnt <= '0;
      else if (busy_i) busy_cnt <= busy_cnt + 1;
      if (start_i)       exp_waddr <= '0;
      else if (out_we_i) exp_waddr <= exp_waddr + 1'b1;
    end
  end

  a_r3_start_sets_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_i);

  // a restart while busy would reset the count and move the falling edge (R5)
  a_r4_busy_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> busy_cnt == BUSY_CYC);

  a_r8_write_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_we_i |-> out_waddr_i == exp_waddr);

  a_r10_idle_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !out_we_i);

  a_r9_rd_idx_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> out_raddr_i == '0);

  a_r1_stat_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i == REG_STAT |-> rdata_i[7:1] == '0);

endmodule

bind dct_coproc dct_coproc_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start),
  .busy_i      (busy),
  .out_we_i    (out_we),
  .out_waddr_i (out_waddr),
  .out_raddr_i (out_raddr),
  .addr_i      (addr_i),
  .rdata_i     (rdata_o)
);

// File: tb/dct_coproc_tb_top.sv
`timescale 1ns/1ps
module dct_coproc_tb_top;

  localparam int BUSY_CYC = 4672;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic       wr = 1'b0;
  logic       rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int pix [64];
  int ct [8][8];

  always #2.5 clk = ~clk;

  dct_coproc dut_i (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .addr_i  (addr),
    .wr_i    (wr),
    .rd_i    (rd),
    .wdata_i (wdata),
    .rdata_o (rdata)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(posedge clk);
    #1 wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd = 1'b1;
    #1 d = rdata;
    @(posedge clk);
    #1 rd = 1'b0;
  endtask

  task automatic rd_coef(output logic [15:0] c);
    logic [7:0] hi, lo;
    bus_rd(2'd1, hi);
    bus_rd(2'd1, lo);
    c = {hi, lo};
  endtask

  // independent model of R6/R7
  function automatic logic [15:0] ref_coef(int u, int v);
    longint s, r, w, res;
    int cu, cv;
    r = 0;
    for (int x = 0; x < 8; x++) begin
      s = 0;
      for (int j = 0; j < 8; j++)
        s += (longint'(pix[x*8+j] * 64) * ct[j][v]) >>> 6;
      r += (s * ct[x][u]) >>> 6;
    end
    cu = (u != 0) ? 64 : 5;
    cv = (v != 0) ? 64 : 5;
    w = (((16 * cu) >> 6) * cv) >> 6;
    res = (r * w) >>> 12;
    return res[15:0];
  endfunction

  task automatic load_block();
    for (int i = 0; i < 64; i++) bus_wr(2'd0, 8'(pix[i]));
  endtask

  task automatic start_wait(output int cyc);
    logic [7:0] st;
    bus_wr(2'd2, 8'h01);
    cyc = 0;
    do begin
      bus_rd(2'd3, st);
      if (st[0]) cyc++;
    end while (st[0] && cyc < 10000);
  endtask

  task automatic check_all(input string tag);
    logic [15:0] c, e;
    int bad = 0;
    for (int k = 0; k < 64; k++) begin
      rd_coef(c);
      e = ref_coef(k / 8, k % 8);
      if (c != e) begin
        bad++;
        chk(1'b0, $sformatf("R6/R7/R8 %s coef %0d", tag, k), int'($signed(c)), int'($signed(e)));
      end
    end
    if (bad == 0) chk(1'b1, "R8", 0, 0);
  endtask

  task automatic run_pattern(input string tag);
    int cyc;
    load_block();
    start_wait(cyc);
    chk(cyc == BUSY_CYC, $sformatf("R4 busy cycles %s", tag), cyc, BUSY_CYC);
    check_all(tag);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    bus_rd(2'd3, d);
    chk(d == 8'h00, "R10 status after reset", d, 0);
    bus_rd(2'd1, d);
    chk(d == 8'h00, "R10 coef hi after reset", d, 0);
    bus_rd(2'd1, d);
    chk(d == 8'h00, "R10 coef lo after reset", d, 0);
    bus_rd(2'd0, d);
    chk(d == 8'h00, "R1 read of pixel reg", d, 0);
  endtask

  task automatic t_zero();
    for (int i = 0; i < 64; i++) pix[i] = 0;
    run_pattern("zero");
  endtask

  task automatic t_flat();
    for (int i = 0; i < 64; i++) pix[i] = 100;
    run_pattern("flat");
  endtask

  task automatic t_impulse();
    for (int i = 0; i < 64; i++) pix[i] = 0;
    pix[3*8+5] = 127;
    run_pattern("impulse");
  endtask

  task automatic t_ramp();
    for (int i = 0; i < 64; i++) pix[i] = i * 2 - 64;
    run_pattern("ramp");
  endtask

  task automatic t_alt_full();
    for (int i = 0; i < 64; i++) pix[i] = (((i / 8) + (i % 8)) % 2 != 0) ? -128 : 127;
    run_pattern("alternating");
  endtask

  task automatic t_random();
    int seed = 12345;
    for (int i = 0; i < 64; i++) begin
      seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
      pix[i] = ((seed >> 16) & 255) - 128;
    end
    run_pattern("random");
  endtask

  task automatic t_cmd_other();
    logic [7:0] d;
    bus_wr(2'd2, 8'h02);
    bus_rd(2'd3, d);
    chk(d == 8'h00, "R3 cmd 0x02 ignored", d, 0);
    bus_wr(2'd2, 8'h81);
    bus_rd(2'd3, d);
    chk(d == 8'h00, "R3 cmd 0x81 ignored", d, 0);
    bus_wr(2'd2, 8'h01);
    bus_rd(2'd3, d);
    chk(d == 8'h01, "R3 cmd 0x01 starts", d, 1);
    while (d[0]) bus_rd(2'd3, d);
    check_all("cmd_start");
  endtask

  task automatic t_busy_restart();
    logic [7:0] st;
    int cyc = 0;
    for (int i = 0; i < 64; i++) pix[i] = (i * 7) % 50 - 20;
    load_block();
    bus_wr(2'd2, 8'h01);
    for (int i = 0; i < 100; i++) begin
      bus_rd(2'd3, st);
      if (st[0]) cyc++;
    end
    bus_wr(2'd2, 8'h01);
    cyc++;  // write cycle in which status was not sampled
    do begin
      bus_rd(2'd3, st);
      if (st[0]) cyc++;
    end while (st[0] && cyc < 10000);
    chk(cyc == BUSY_CYC, "R5 restart during busy ignored", cyc, BUSY_CYC);
    check_all("restart");
  endtask

  task automatic t_rd_wrap();
    logic [15:0] c;
    logic [7:0] d;
    int cyc;
    rd_coef(c);
    chk(c == ref_coef(0, 0), "R9 read index wraps to 0", int'($signed(c)), int'($signed(ref_coef(0, 0))));
    bus_rd(2'd1, d);
    start_wait(cyc);
    rd_coef(c);
    chk(c == ref_coef(0, 0), "R9 read index reset by start", int'($signed(c)), int'($signed(ref_coef(0, 0))));
  endtask

  task automatic t_wr_wrap();
    int cyc;
    for (int i = 0; i < 64; i++) pix[i] = 30 - i;
    load_block();
    for (int i = 0; i < 5; i++) begin
      bus_wr(2'd0, 8'(-90 + i * 11));
      pix[i] = -90 + i * 11;
    end
    start_wait(cyc);
    chk(cyc == BUSY_CYC, "R2 busy cycles wrap", cyc, BUSY_CYC);
    check_all("R2 write wrap");
  endtask

  initial begin
    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 8; b++)
        ct[a][b] = $rtoi(64.0 * $cos((2.0 * a + 1.0) * b * 3.14159265358979 / 16.0));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_zero();
    t_flat();
    t_impulse();
    t_ramp();
    t_alt_full();
    t_random();
    t_cmd_other();
    t_busy_restart();
    t_rd_wrap();
    t_wr_wrap();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule